// File: doc/BRIEF.md
# Tagged Read Request Splitter

This block sits on the outgoing request path of a packet-based serial link. The application hands it one read request, given as a start address and a byte length, together with a selector for the largest read the link partner allows. The block cuts the request into segments. Each segment fits within that largest size and stays inside one 4 KB address page. Each segment leaves with a tag taken from a pool of 32. No tag is handed out twice while it is still in flight.

Completions come back carrying a tag and a status. A successful completion that is marked as the final one for its tag releases the tag. An error status (unsupported request, completer abort, or the reserved code) also releases the tag, and the error is reported to the application one cycle later. A completion whose tag is not in flight is flagged as stray and changes nothing. When all tags are busy, segment issue waits until a completion frees one.

The control is a three-state machine:
- `ST_IDLE` accepts a request. A valid request moves it to `ST_ISSUE`; an invalid one is dropped and it stays in `ST_IDLE`.
- `ST_ISSUE` offers segments. After the handshake of the last segment it returns to `ST_IDLE`. If the pool is empty it moves to `ST_STALL`.
- `ST_STALL` waits for a free tag and then returns to `ST_ISSUE`.

Top module: `rd_splitter`

## Requirements
- R1: A tag is never presented on `seg_tag` while it is in flight. The tag offered is the lowest-numbered free tag at the cycle of the segment handshake.
- R2: `seg_len` is never zero and never exceeds the selected maximum. `req_mrrs` codes 0..5 select 128, 256, 512, 1024, 2048 and 4096 bytes (128 shifted left by the code). The code is captured when the request is accepted.
- R3: No segment crosses a 4 KB boundary: `seg_addr[11:0] + seg_len <= 4096`.
- R4: Each segment is as long as the smallest of three values: the bytes still owed, the selected maximum, and the bytes left to the next 4 KB boundary. Segments come out in address order, each starting where the previous one ended, and their lengths add up to `req_len`.
- R5: While all 32 tags are in flight, `seg_valid` stays low. The first tag freed is the one used by the next segment.
- R6: A completion with status 00 (success) and `cpl_last`=1 frees its tag. With `cpl_last`=0 the tag stays in flight.
- R7: A completion for an in-flight tag with status 01 (unsupported request), 10 (completer abort) or 11 (reserved) frees the tag. In the next cycle it raises `cpl_err` for one cycle, with `cpl_err_tag` and `cpl_err_status` holding the tag and status.
- R8: A completion whose tag is not in flight raises `cpl_stray` for one cycle in the next cycle. It raises no `cpl_err` and frees nothing.
- R9: A request with `req_len`=0 or `req_mrrs` greater than 5 is accepted and discarded. `req_err` pulses for one cycle in the next cycle, and no segment is issued.
- R10: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_addr` and `seg_len` hold their values.
- R11: After reset no tag is in flight, `seg_valid` is low, `req_ready` is high, and the three report outputs are low.
- R12: `req_ready` is high only in `ST_IDLE`. A new request is taken only after the last segment of the previous one has been handed over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Application read request present |
| req_ready | output | 1 | Splitter can take a request |
| req_addr | input | ADDR_W (32) | Start byte address |
| req_len | input | LEN_W (16) | Length in bytes |
| req_mrrs | input | 3 | Maximum read size code (0..5) |
| req_err | output | 1 | Pulse: request discarded as invalid |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Downstream takes the segment |
| seg_addr | output | ADDR_W (32) | Segment start address |
| seg_len | output | 13 | Segment length in bytes |
| seg_tag | output | TAG_W (5) | Tag of the segment |
| cpl_valid | input | 1 | Completion present |
| cpl_tag | input | TAG_W (5) | Completion tag |
| cpl_status | input | 2 | 00 success, 01 unsupported request, 10 completer abort, 11 reserved |
| cpl_last | input | 1 | Final completion for this tag |
| cpl_err | output | 1 | Pulse: error completion seen |
| cpl_err_tag | output | TAG_W (5) | Tag of the error completion |
| cpl_err_status | output | 2 | Status of the error completion |
| cpl_stray | output | 1 | Pulse: completion for a tag not in flight |

## Verification
A tag map that is out of step with the link shows at the ports in one of two ways. Either a tag is handed out a second time before its completion, or the next tag is not the lowest free one. The bench models the pool independently, so this is caught at the very next handshake. It also shows as a stray or error flag whose value differs from the one predicted one cycle after a completion. A corrupted address or remaining-byte register shows on the next segment as a wrong length or start address, or as a wrong segment count. Stalls are checked cycle by cycle against the bench's own count of busy tags.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int SEG_W = 13;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_STALL = 2'd2
    } rs_state_e;

    localparam logic [1:0] CPL_OK = 2'b00;

    function automatic logic [SEG_W-1:0] mrrs_bytes(input logic [2:0] code);
        mrrs_bytes = 13'd128 << code;
    endfunction

    function automatic logic mrrs_legal(input logic [2:0] code);
        mrrs_legal = (code <= 3'd5);
    endfunction
endpackage

// File: rtl/rs_seg_calc.sv
module rs_seg_calc
    import rs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [11:0]      page_off,
    input  logic [LEN_W-1:0] remain,
    input  logic [2:0]       mrrs_code,
    output logic [SEG_W-1:0] seg_len
);
    logic [SEG_W-1:0] to_page_end;
    logic [SEG_W-1:0] size_cap;
    logic [SEG_W-1:0] cap;

    always_comb begin
        to_page_end = 13'd4096 - {1'b0, page_off};
        size_cap    = mrrs_bytes(mrrs_code);
        cap         = (size_cap < to_page_end) ? size_cap : to_page_end;
        if (remain < LEN_W'(cap))
            seg_len = SEG_W'(remain);
        else
            seg_len = cap;
    end
endmodule

// File: rtl/rs_tag_pool.sv
module rs_tag_pool #(
    parameter int TAG_N = 32,
    localparam int TAG_W = $clog2(TAG_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             free_en,
    input  logic [TAG_W-1:0] free_tag,
    input  logic [TAG_W-1:0] query_tag,
    output logic             any_free,
    output logic [TAG_W-1:0] alloc_tag,
    output logic             query_busy
);
    logic [TAG_N-1:0] busy_q;

    always_comb begin
        alloc_tag = '0;
        for (int i = TAG_N - 1; i >= 0; i--) begin
            if (!busy_q[i]) alloc_tag = TAG_W'(i);
        end
    end

    assign any_free   = ~&busy_q;
    assign query_busy = busy_q[query_tag];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            if (free_en)  busy_q[free_tag]  <= 1'b0;
            if (alloc_en) busy_q[alloc_tag] <= 1'b1;
        end
    end

    // R5
    no_alloc_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> any_free);

    // R1
    free_only_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> busy_q[free_tag]);

    // R1
    alloc_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> busy_q[$past(alloc_tag)]);
endmodule

// File: rtl/rs_cpl_check.sv
module rs_cpl_check
    import rs_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [1:0]       cpl_status,
    input  logic             cpl_last,
    input  logic             tag_busy,
    output logic             free_en,
    output logic [TAG_W-1:0] free_tag,
    output logic             cpl_err,
    output logic [TAG_W-1:0] cpl_err_tag,
    output logic [1:0]       cpl_err_status,
    output logic             cpl_stray
);
    logic hit;
    logic bad;

    assign hit      = cpl_valid && tag_busy;
    assign bad      = (cpl_status != CPL_OK);
    assign free_en  = hit && (bad || cpl_last);
    assign free_tag = cpl_tag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_err        <= 1'b0;
            cpl_err_tag    <= '0;
            cpl_err_status <= CPL_OK;
            cpl_stray      <= 1'b0;
        end else begin
            cpl_err   <= hit && bad;
            cpl_stray <= cpl_valid && !tag_busy;
            if (hit && bad) begin
                cpl_err_tag    <= cpl_tag;
                cpl_err_status <= cpl_status;
            end
        end
    end

    // R7
    err_follows_bad_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && tag_busy && cpl_status != CPL_OK) |=> (cpl_err && cpl_err_tag == $past(cpl_tag)));

    // R8
    stray_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !tag_busy) |=> (cpl_stray && !cpl_err));

    // R7
    err_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_err |-> $past(cpl_valid));
endmodule

// File: rtl/rd_splitter.sv
module rd_splitter
    import rs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int TAG_N  = 32,
    localparam int TAG_W = $clog2(TAG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [2:0]        req_mrrs,
    output logic              req_err,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [SEG_W-1:0]  seg_len,
    output logic [TAG_W-1:0]  seg_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic [1:0]        cpl_status,
    input  logic              cpl_last,
    output logic              cpl_err,
    output logic [TAG_W-1:0]  cpl_err_tag,
    output logic [1:0]        cpl_err_status,
    output logic              cpl_stray
);
    rs_state_e         state_q, state_d;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [2:0]        code_q;
    logic              req_err_q;

    logic             any_free;
    logic [TAG_W-1:0] alloc_tag;
    logic             tag_busy;
    logic             free_en;
    logic [TAG_W-1:0] free_tag;
    logic             take_req;
    logic             req_bad;
    logic             fire;
    logic             last_seg;

    rs_seg_calc #(.LEN_W(LEN_W)) u_calc (
        .page_off  (cur_addr_q[11:0]),
        .remain    (remain_q),
        .mrrs_code (code_q),
        .seg_len   (seg_len)
    );

    rs_tag_pool #(.TAG_N(TAG_N)) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (fire),
        .free_en    (free_en),
        .free_tag   (free_tag),
        .query_tag  (cpl_tag),
        .any_free   (any_free),
        .alloc_tag  (alloc_tag),
        .query_busy (tag_busy)
    );

    rs_cpl_check #(.TAG_W(TAG_W)) u_cpl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpl_valid      (cpl_valid),
        .cpl_tag        (cpl_tag),
        .cpl_status     (cpl_status),
        .cpl_last       (cpl_last),
        .tag_busy       (tag_busy),
        .free_en        (free_en),
        .free_tag       (free_tag),
        .cpl_err        (cpl_err),
        .cpl_err_tag    (cpl_err_tag),
        .cpl_err_status (cpl_err_status),
        .cpl_stray      (cpl_stray)
    );

    assign req_bad  = (req_len == '0) || !mrrs_legal(req_mrrs);
    assign take_req = req_ready && req_valid;
    assign fire     = seg_valid && seg_ready;
    assign last_seg = (remain_q == LEN_W'(seg_len));

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid && !req_bad) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (fire && last_seg) state_d = ST_IDLE;
                else if (!any_free)   state_d = ST_STALL;
            end
            ST_STALL: if (any_free) state_d = ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        seg_valid = (state_q == ST_ISSUE) && any_free;
        seg_addr  = cur_addr_q;
        seg_tag   = alloc_tag;
        req_err   = req_err_q;
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cur_addr_q <= '0;
            remain_q   <= '0;
            code_q     <= '0;
            req_err_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            req_err_q <= take_req && req_bad;
            if (take_req && !req_bad) begin
                cur_addr_q <= req_addr;
                remain_q   <= req_len;
                code_q     <= req_mrrs;
            end else if (fire) begin
                cur_addr_q <= cur_addr_q + ADDR_W'(seg_len);
                remain_q   <= remain_q - LEN_W'(seg_len);
            end
        end
    end

    // R2
    seg_size_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_len != '0 && seg_len <= mrrs_bytes(code_q)));

    // R3
    no_page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (({1'b0, seg_addr[11:0]} + seg_len) <= 13'd4096));

    // R10
    hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));

    // R9
    req_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> ($past(req_valid && req_ready) && !seg_valid));

    // R12
    ready_excludes_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !seg_valid);
endmodule

// File: tb/rd_splitter_test.sv
`timescale 1ns/1ps
module rd_splitter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [2:0]  req_mrrs = '0;
    logic        req_err;
    logic        seg_valid;
    logic        seg_ready = 1'b1;
    logic [31:0] seg_addr;
    logic [12:0] seg_len;
    logic [4:0]  seg_tag;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_tag = '0;
    logic [1:0]  cpl_status = '0;
    logic        cpl_last = 1'b0;
    logic        cpl_err;
    logic [4:0]  cpl_err_tag;
    logic [1:0]  cpl_err_status;
    logic        cpl_stray;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit [31:0] model_busy = '0;

    always #10 clk = ~clk;

    rd_splitter uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_mrrs(req_mrrs), .req_err(req_err),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_tag(seg_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
        .cpl_last(cpl_last), .cpl_err(cpl_err), .cpl_err_tag(cpl_err_tag),
        .cpl_err_status(cpl_err_status), .cpl_stray(cpl_stray)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < 32; i++) if (!model_busy[i]) return i;
        return -1;
    endfunction

    task automatic send_req(input logic [31:0] a, input int len, input int code);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = 16'(len); req_mrrs = 3'(code);
        #1 chk(req_ready == 1'b1, "R12 ready in idle", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic expect_segs(input logic [31:0] a, input int len, input int code);
        logic [31:0] addr = a;
        int rem = len;
        while (rem > 0) begin
            int lim = 128 << code;
            int bnd = 4096 - int'(addr[11:0]);
            int l = rem;
            int n = 0;
            int t;
            if (lim < l) l = lim;
            if (bnd < l) l = bnd;
            t = lowest_free();
            while (!seg_valid && n < 50) begin
                @(negedge clk); #1; n++;
            end
            chk(seg_valid == 1'b1, "R5 segment offered", 32'(seg_valid), 1);
            chk(seg_addr == addr, "R4 segment address", seg_addr, addr);
            chk(int'(seg_len) == l, "R4 segment length (R2/R3 limits)", 32'(seg_len), 32'(l));
            chk(int'(seg_tag) == t, "R1 lowest free tag", 32'(seg_tag), 32'(t));
            if (t >= 0) model_busy[t] = 1'b1;
            addr = addr + 32'(l);
            rem  = rem - l;
            @(negedge clk); #1;
        end
        chk(seg_valid == 1'b0, "R4 no extra segment", 32'(seg_valid), 0);
        chk(req_ready == 1'b1, "R12 back to idle", 32'(req_ready), 1);
    endtask

    task automatic send_cpl(input int t, input int st, input bit last);
        bit inflight = model_busy[t];
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = 5'(t); cpl_status = 2'(st); cpl_last = last;
        @(negedge clk);
        cpl_valid = 1'b0;
        #1;
        chk(cpl_err == (inflight && st != 0), "R7 error flag", 32'(cpl_err), 32'(inflight && st != 0));
        chk(cpl_stray == !inflight, "R8 stray flag", 32'(cpl_stray), 32'(!inflight));
        if (inflight && st != 0) begin
            chk(int'(cpl_err_tag) == t, "R7 error tag", 32'(cpl_err_tag), 32'(t));
            chk(int'(cpl_err_status) == st, "R7 error status", 32'(cpl_err_status), 32'(st));
        end
        if (inflight && (st != 0 || last)) model_busy[t] = 1'b0;
    endtask

    task automatic drain_all();
        for (int i = 0; i < 32; i++) if (model_busy[i]) send_cpl(i, 0, 1'b1);
    endtask

    task automatic t_reset();
        #1;
        chk(seg_valid == 0, "R11 seg_valid low", 32'(seg_valid), 0);
        chk(req_ready == 1, "R11 req_ready high", 32'(req_ready), 1);
        chk(!cpl_err && !cpl_stray && !req_err, "R11 flags low",
            {29'd0, cpl_err, cpl_stray, req_err}, 0);
    endtask

    task automatic t_basic_split();
        send_req(32'h100, 600, 1);
        expect_segs(32'h100, 600, 1);
    endtask

    task automatic t_completions();
        send_cpl(1, 0, 1'b0);                 // R6 non-final keeps tag 1
        send_cpl(0, 0, 1'b1);                 // R6 final frees tag 0
        send_req(32'h40, 64, 1);
        expect_segs(32'h40, 64, 1);           // expects tag 0 again
        send_cpl(2, 1, 1'b0);                 // R7 unsupported request
        send_cpl(1, 2, 1'b0);                 // R7 completer abort
        send_cpl(20, 0, 1'b1);                // R8 stray
        send_req(32'h80, 100, 0);
        expect_segs(32'h80, 100, 0);          // R8 stray freed nothing
    endtask

    task automatic t_page_boundary();
        send_req(32'hF80, 512, 2);
        expect_segs(32'hF80, 512, 2);         // R3 split at 0x1000
        send_req(32'h1234, 5000, 5);
        expect_segs(32'h1234, 5000, 5);       // R4 4096 limit, unaligned
    endtask

    task automatic t_invalid();
        send_req(32'h500, 0, 1);
        chk(req_err == 1'b1, "R9 zero length flagged", 32'(req_err), 1);
        chk(seg_valid == 1'b0, "R9 no segment", 32'(seg_valid), 0);
        @(negedge clk); #1;
        chk(req_err == 1'b0, "R9 single pulse", 32'(req_err), 0);
        send_req(32'h500, 64, 6);
        chk(req_err == 1'b1, "R9 bad size code flagged", 32'(req_err), 1);
        chk(seg_valid == 1'b0 && req_ready == 1'b1, "R9 discarded", 32'(seg_valid), 0);
    endtask

    task automatic t_backpressure();
        seg_ready = 1'b0;
        send_req(32'h3000, 300, 1);
        for (int i = 0; i < 3; i++) begin
            chk(seg_valid == 1'b1, "R10 valid held", 32'(seg_valid), 1);
            chk(seg_addr == 32'h3000 && seg_len == 13'd256, "R10 segment held", seg_addr, 32'h3000);
            chk(req_ready == 1'b0, "R12 busy refuses request", 32'(req_ready), 0);
            @(negedge clk); #1;
        end
        seg_ready = 1'b1;
        expect_segs(32'h3000, 300, 1);
    endtask

    task automatic t_exhaust();
        drain_all();
        send_req(32'h0, 4096, 0);
        expect_segs(32'h0, 4096, 0);          // tags 0..31 now in flight
        send_req(32'h2000, 128, 0);
        for (int i = 0; i < 5; i++) begin
            chk(seg_valid == 1'b0, "R5 stall while pool empty", 32'(seg_valid), 0);
            @(negedge clk); #1;
        end
        send_cpl(7, 0, 1'b1);
        expect_segs(32'h2000, 128, 0);        // R5 reuses tag 7
        drain_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic_split();
        t_completions();
        t_page_boundary();
        t_invalid();
        t_backpressure();
        t_exhaust();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule